// File: doc/BRIEF.md
# Staged Bidirectional Barrel Shifter

This block moves a 16-bit word left or right by any distance from 0 to 15 positions within a single combinational pass. The distance is given as a 4-bit binary amount. Each bit of the amount switches one fixed-distance stage on or off. The stages move the word by 1, 2, 4 and 8 places. They are chained from the smallest distance to the largest, so the distances of the enabled stages add up to the requested amount.

A single direction input steers every stage the same way. The shift is logical: positions left empty are filled with zeros, and bits pushed past either end are lost. Each stage is a row of identical per-bit four-way selectors. Each selector picks the bit in its own position, the bit one stage distance below it, or the bit one stage distance above it. A block-wide enable forces the result to zero when it is low.

The shifter is intended for a single-cycle datapath. The surrounding logic presents an operand, an amount and a direction, and takes the result in the same cycle.

Top module: `stage_barrel_shifter`

## Requirements
- R1: When `en` is 0, `data_out` is 16'h0000 whatever the other inputs are.
- R2: When `en` is 1 and `shamt` is 0, `data_out` equals `data_in` for both values of `dir_right`.
- R3: When `en` is 1 and `dir_right` is 0, the shift is to the left: `data_out` equals `data_in` shifted toward bit 15 by `shamt` places.
- R4: When `en` is 1 and `dir_right` is 1, the shift is to the right: `data_out` equals `data_in` shifted toward bit 0 by `shamt` places.
- R5: Bit k of `shamt` enables the stage of distance 2^k, with k from 0 to 3. The total move is the binary value of `shamt`, for example 5 = 4 + 1 and 10 = 8 + 2.
- R6: The largest amount is 15. Shifting left by 15 leaves only old bit 0, now at bit 15. Shifting right by 15 leaves only old bit 15, now at bit 0.
- R7: Vacated positions are zero. After a left shift by n, the low n bits are 0. After a right shift by n, the high n bits are 0. The result never has more 1 bits than the input.
- R8: Bits moved past either end are discarded and do not wrap around. For example, 16'hFFFF shifted left by 8 gives 16'hFF00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 16 | Operand to be shifted |
| shamt | input | 4 | Shift amount; bit k enables the 2^k stage |
| dir_right | input | 1 | Direction: 0 shifts left, 1 shifts right |
| en | input | 1 | Block enable; 0 forces the output to zero |
| data_out | output | 16 | Shifted result |

## Verification
Every amount from 0 to 15 is applied in both directions to several operands: a single 1 at bit 0, a single 1 at bit 15, all ones, and alternating and irregular patterns. The lone-bit operands show where each stage moves a bit, so a stage wired to the wrong distance shows up. The all-ones word shows that the fill is zero and that nothing wraps around. The irregular patterns show that bit order is kept. Zero amounts and disabled cycles with non-zero operands separate the pass-through path from the gating.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  // Distance of stage k in the cascade.
  function automatic int unsigned stage_dist(input int unsigned k);
    return 32'd1 << k;
  endfunction

  // Number of 1 bits in a 16-bit word.
  function automatic int unsigned ones16(input logic [15:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  // Mask with the low n bits set.
  function automatic logic [15:0] low_mask(input int unsigned n);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  // Encodings of the per-bit selector: {shift_on, dir_right}.
  typedef enum logic [1:0] {
    SEL_HOLD_L  = 2'b00,
    SEL_HOLD_R  = 2'b01,
    SEL_FROM_LO = 2'b10,
    SEL_FROM_HI = 2'b11
  } slice_sel_e;

endpackage

// File: rtl/bsh_slice.sv
module bsh_slice
  import bsh_pkg::*;
(
  input  logic self_bit,
  input  logic lo_bit,
  input  logic hi_bit,
  input  logic shift_on,
  input  logic dir_right,
  input  logic en,
  output logic out_bit
);
  slice_sel_e sel;
  logic       picked;

  assign sel = slice_sel_e'({shift_on, dir_right});

  always_comb begin
    unique case (sel)
      SEL_HOLD_L, SEL_HOLD_R: picked = self_bit;
      SEL_FROM_LO:            picked = lo_bit;
      SEL_FROM_HI:            picked = hi_bit;
      default:                picked = 1'b0;
    endcase
  end

  assign out_bit = en & picked;
endmodule

// File: rtl/bsh_stage.sv
module bsh_stage
  import bsh_pkg::*;
#(
  parameter int W    = 16,
  parameter int DIST = 1
) (
  input  logic [W-1:0] stage_in,
  input  logic         shift_on,
  input  logic         dir_right,
  input  logic         en,
  output logic [W-1:0] stage_out
);
  localparam int FILL = (DIST < W) ? DIST : W;

  for (genvar n = 0; n < W; n++) begin : g_bit
    logic lo_b, hi_b;
    if (n >= DIST) begin : g_lo
      assign lo_b = stage_in[n-DIST];
    end else begin : g_lo_zero
      assign lo_b = 1'b0;
    end
    if (n + DIST < W) begin : g_hi
      assign hi_b = stage_in[n+DIST];
    end else begin : g_hi_zero
      assign hi_b = 1'b0;
    end
    bsh_slice u_slice (
      .self_bit (stage_in[n]),
      .lo_bit   (lo_b),
      .hi_bit   (hi_b),
      .shift_on (shift_on),
      .dir_right(dir_right),
      .en       (en),
      .out_bit  (stage_out[n])
    );
  end

  // Named views of the vacated edge for the checks below.
  logic [FILL-1:0] low_edge, high_edge;
  assign low_edge  = stage_out[FILL-1:0];
  assign high_edge = stage_out[W-1:W-FILL];

  always_comb begin
    if (en && !shift_on)
      AST_STAGE_PASS: assert (stage_out == stage_in); // R5
    if (en && shift_on && !dir_right)
      AST_STAGE_LFILL: assert (low_edge == '0); // R7
    if (en && shift_on && dir_right)
      AST_STAGE_RFILL: assert (high_edge == '0); // R7
  end
endmodule

// File: rtl/stage_barrel_shifter.sv
module stage_barrel_shifter
  import bsh_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         data_in,
  input  logic [$clog2(W)-1:0] shamt,
  input  logic                 dir_right,
  input  logic                 en,
  output logic [W-1:0]         data_out
);
  localparam int SW = $clog2(W);

  logic [W-1:0] chain [SW+1];
  assign chain[0] = data_in;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    bsh_stage #(.W(W), .DIST(1 << k)) u_stage (
      .stage_in (chain[k]),
      .shift_on (shamt[k]),
      .dir_right(dir_right),
      .en       (en),
      .stage_out(chain[k+1])
    );
  end

  assign data_out = chain[SW];

  // Named events for the checks.
  logic amount_zero, gated_off;
  assign amount_zero = (shamt == '0);
  assign gated_off   = !en;

  always_comb begin
    if (gated_off)
      AST_GATED_ZERO: assert (data_out == '0); // R1
    if (en && amount_zero)
      AST_ZERO_PASS: assert (data_out == data_in); // R2
    if (W == 16)
      AST_NO_NEW_ONES: assert (ones16(16'(data_out)) <= ones16(16'(data_in))); // R7
    if (en && W == 16 && !dir_right)
      AST_LEFT_LOW_ZERO: assert ((16'(data_out) & low_mask(shamt)) == '0); // R3
    if (en && W == 16 && dir_right)
      AST_RIGHT_HIGH_ZERO: assert ((16'(data_out) & ~(16'hFFFF >> shamt)) == '0); // R4
  end
endmodule

// File: tb/tb_stage_barrel_shifter.sv
module tb_stage_barrel_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic [15:0] data_in = '0;
  logic [3:0]  shamt = '0;
  logic        dir_right = 1'b0;
  logic        en = 1'b0;
  logic [15:0] data_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stage_barrel_shifter dut (
    .data_in  (data_in),
    .shamt    (shamt),
    .dir_right(dir_right),
    .en       (en),
    .data_out (data_out)
  );

  // Reference model: word-level shift, independent of the stage chain.
  function automatic logic [15:0] model(input logic [15:0] a, input int n,
                                        input logic r, input logic e);
    logic [31:0] wide;
    if (!e) return 16'h0000;
    if (r) wide = {16'h0, a} >> n;
    else   wide = {16'h0, a} << n;
    return wide[15:0];
  endfunction

  task automatic drive(input logic [15:0] a, input int n, input logic r,
                       input logic e, input string tag);
    item_t it;
    @(posedge clk);
    data_in   <= a;
    shamt     <= 4'(n);
    dir_right <= r;
    en        <= e;
    it.exp = model(a, n, r, e);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare at the falling edge, away from input changes.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (data_out !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h (in=%h sh=%0d r=%b en=%b)",
                 it.tag, data_out, it.exp, data_in, shamt, dir_right, en);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [6];
    pats[0] = 16'h0001; pats[1] = 16'h8000; pats[2] = 16'hFFFF;
    pats[3] = 16'hAAAA; pats[4] = 16'h5A3C; pats[5] = 16'hC0DE;

    // Initial state: disabled, output zero.
    drive(16'h0000, 0, 1'b0, 1'b0, "R1 initial");
    // R1: gating with live operands.
    drive(16'hFFFF, 0, 1'b0, 1'b0, "R1 gated");
    drive(16'h1234, 7, 1'b1, 1'b0, "R1 gated");
    // R2: zero amount, both directions.
    drive(16'hBEEF, 0, 1'b0, 1'b1, "R2 left");
    drive(16'hBEEF, 0, 1'b1, 1'b1, "R2 right");
    // R3 / R4: full sweep of amounts and directions.
    for (int p = 0; p < 6; p++)
      for (int n = 0; n < 16; n++) begin
        drive(pats[p], n, 1'b0, 1'b1, "R3 left sweep");
        drive(pats[p], n, 1'b1, 1'b1, "R4 right sweep");
      end
    // R5: composite amounts.
    drive(16'h0001, 5,  1'b0, 1'b1, "R5 amount 4+1");
    drive(16'h8000, 10, 1'b1, 1'b1, "R5 amount 8+2");
    // R6: extreme amount.
    drive(16'hFFFF, 15, 1'b0, 1'b1, "R6 left 15");
    drive(16'hFFFF, 15, 1'b1, 1'b1, "R6 right 15");
    // R7: zero fill on vacated positions.
    drive(16'hFFFF, 3, 1'b0, 1'b1, "R7 low fill");
    drive(16'hFFFF, 3, 1'b1, 1'b1, "R7 high fill");
    // R8: no wrap-around.
    drive(16'hFFFF, 8, 1'b0, 1'b1, "R8 no wrap left");
    drive(16'h00FF, 8, 1'b1, 1'b1, "R8 no wrap right");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule